// File: doc/BRIEF.md
# Single-Shot Successive-Approximation Conversion Sequencer

This block is the digital sequencer of a 10-bit successive-approximation analog-to-digital converter. Software writes a control register with its start flag set. The block then runs exactly one conversion: a fixed sampling window, followed by a binary search of one bit per clock from the most significant bit down. The search drives a trial code to an external DAC and reads back an external comparator. When the search ends, the block writes the code into two byte-wide result registers and pulses an interrupt. It also clears the start flag, so software can poll that flag as a busy indication.

The conversion-end cycle is where bus traffic and the internal write-back can collide, and the block resolves each collision by a fixed rule. If software reads a result register in that cycle, the read sees the old value and the write-back waits until the read has finished. If software writes the control register in that cycle, the write wins outright: the result registers keep their old contents, no interrupt is raised, and the control register takes the written value. Clearing the start flag while a conversion is running cancels it and leaves the earlier result in place.

Top module: `adc_sar_top`

## Requirements
- R1: Writing the control register (address 0) with bit 7 set while idle starts exactly one conversion. Bit 7 then reads back as 1 until the conversion ends. Writing bit 7 as 1 again during a conversion does not restart it or change its timing, but the written bits 6:0 are stored.
- R2: When a conversion completes, bit 7 of the control register returns to 0 by itself, and bits 6:0 keep their last written value.
- R3: Counting the write edge as edge 0, a conversion samples for 4 cycles and then makes 10 bit decisions, one per cycle. The result and the interrupt therefore appear right after edge 15.
- R4: Each decision tests a trial code made of the bits already kept plus the current bit set to 1. The decisions run from bit 9 down to bit 0. The first trial code is 0x200. A comparator input of 1 keeps the trial bit. With the comparator reporting "trial code <= input level", the result equals that level.
- R5: Address 1 reads result bits 9:2. Address 2 reads result bits 1:0 in its bits 7:6, with bits 5:0 reading 0.
- R6: After reset, the control register and both result registers read 0x00 and the interrupt is low.
- R7: The interrupt is a pulse of exactly one cycle, raised on the same edge that updates the result registers. The result registers change at no other time.
- R8: A result-register read (bus_rd at address 1 or 2) in the conversion-end cycle returns the previous result. The result update and the interrupt are then delayed by one cycle.
- R9: A control-register write in the conversion-end cycle suppresses both the result update and the interrupt, and the control register takes the written value. If bit 7 was written as 1, a fresh conversion starts with R3 timing.
- R10: Writing bit 7 as 0 during sampling or conversion aborts the conversion. The block returns to idle, no interrupt follows, and the previous result remains.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_addr | input | 2 | Register address: 0 control, 1 result high, 2 result low |
| bus_wr | input | 1 | Write strobe, sampled on the rising edge |
| bus_rd | input | 1 | Read strobe, used only for conflict resolution |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr (combinational) |
| cmp_in | input | 1 | Comparator: 1 keeps the current trial bit |
| dac_code | output | 10 | Trial code driven to the DAC |
| eoc_irq | output | 1 | One-cycle conversion-end interrupt |

## Verification
The hardest situations to reach are the two collisions. Each one needs a bus operation to land exactly on the single conversion-end cycle, which exists for only one clock per conversion. The bench counts edges from the start write to reach that cycle. It then places a result read or a control write there and compares the delayed or suppressed outcome against its own model. Random rounds draw the input level, the scenario, the abort step and the written control value from a seeded generator, so the collision, restart and abort paths are hit many times with varied data.

// File: rtl/adc_sar_pkg.sv
// Package: shared phase encoding and register map for the conversion sequencer.
// Assumes a two-bit register address space.
package adc_sar_pkg;
    typedef enum logic [1:0] {
        PH_IDLE   = 2'd0,
        PH_SAMPLE = 2'd1,
        PH_CONV   = 2'd2,
        PH_DONE   = 2'd3
    } phase_t;

    localparam logic [1:0] ADDR_CTRL   = 2'd0;
    localparam logic [1:0] ADDR_RES_HI = 2'd1;
    localparam logic [1:0] ADDR_RES_LO = 2'd2;
    localparam int         START_BIT   = 7;
endpackage

// File: rtl/adc_sar_ctrl.sv
// Module: phase sequencer. Steps through idle, sampling, bit decisions and the
// conversion-end cycle, and resolves the bus conflicts in that last cycle.
// Assumes the control-write and result-read decodes are single-cycle strobes.
module adc_sar_ctrl
    import adc_sar_pkg::*;
#(
    parameter int RES_BITS      = 10,
    parameter int SAMPLE_CYCLES = 4,
    parameter int CNT_W         = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ctrl_wr,
    input  logic             start_w,
    input  logic             rd_res,
    output phase_t           phase,
    output logic [CNT_W-1:0] step_idx,
    output logic             load_sar,
    output logic             step_en,
    output logic             commit
);
    localparam logic [CNT_W-1:0] LAST_SAMPLE = CNT_W'(SAMPLE_CYCLES - 1);
    localparam logic [CNT_W-1:0] TOP_BIT     = CNT_W'(RES_BITS - 1);

    phase_t           phase_q, phase_n;
    logic [CNT_W-1:0] cnt_q, cnt_n;
    logic             abort;

    // Purpose: decode a cancel request (start flag written as 0).
    always_comb begin
        abort = ctrl_wr && !start_w;
    end

    // Purpose: strobes to the datapath, including the end-cycle arbitration.
    always_comb begin
        load_sar = ctrl_wr && start_w && (phase_q == PH_IDLE || phase_q == PH_DONE);
        step_en  = (phase_q == PH_CONV) && !abort;
        commit   = (phase_q == PH_DONE) && !ctrl_wr && !rd_res;
    end

    // Purpose: next-phase and counter logic.
    always_comb begin
        phase_n = phase_q;
        cnt_n   = cnt_q;
        case (phase_q)
            PH_IDLE: begin
                if (ctrl_wr && start_w) begin
                    phase_n = PH_SAMPLE;
                    cnt_n   = '0;
                end
            end
            PH_SAMPLE: begin
                if (abort) begin
                    phase_n = PH_IDLE;
                end else if (cnt_q == LAST_SAMPLE) begin
                    phase_n = PH_CONV;
                    cnt_n   = TOP_BIT;
                end else begin
                    cnt_n = cnt_q + 1'b1;
                end
            end
            PH_CONV: begin
                if (abort) begin
                    phase_n = PH_IDLE;
                end else if (cnt_q == '0) begin
                    phase_n = PH_DONE;
                end else begin
                    cnt_n = cnt_q - 1'b1;
                end
            end
            PH_DONE: begin
                if (ctrl_wr) begin
                    phase_n = start_w ? PH_SAMPLE : PH_IDLE;
                    cnt_n   = '0;
                end else if (!rd_res) begin
                    phase_n = PH_IDLE;
                end
            end
            default: phase_n = PH_IDLE;
        endcase
    end

    // Purpose: phase and counter registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else begin
            phase_q <= phase_n;
            cnt_q   <= cnt_n;
        end
    end

    assign phase    = phase_q;
    assign step_idx = cnt_q;
endmodule

// File: rtl/adc_sar_approx.sv
// Module: successive-approximation register. Clears at conversion start, and
// keeps the current trial bit when the comparator reports 1.
// Assumes step_idx is below RES_BITS whenever in_conv is high.
module adc_sar_approx #(
    parameter int RES_BITS = 10,
    parameter int CNT_W    = 4
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                load,
    input  logic                step_en,
    input  logic                in_conv,
    input  logic [CNT_W-1:0]    step_idx,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic [RES_BITS-1:0] sar_val
);
    logic [RES_BITS-1:0] sar_q;
    logic [RES_BITS-1:0] bit_sel;

    // Purpose: one-hot mask of the bit under test.
    always_comb begin
        bit_sel = RES_BITS'(1) << step_idx;
    end

    // Purpose: approximation register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sar_q <= '0;
        end else if (load) begin
            sar_q <= '0;
        end else if (step_en && cmp_in) begin
            sar_q <= sar_q | bit_sel;
        end
    end

    // Purpose: trial code while converting, settled code otherwise.
    always_comb begin
        dac_code = in_conv ? (sar_q | bit_sel) : sar_q;
    end

    assign sar_val = sar_q;
endmodule

// File: rtl/adc_sar_regs.sv
// Module: control and result registers plus the interrupt flop. The result is
// loaded only on commit, and the interrupt follows commit on the same edge.
// Assumes RES_BITS lies between DATA_W+1 and 2*DATA_W-1.
module adc_sar_regs
    import adc_sar_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int DATA_W   = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_wr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic                commit,
    input  logic [RES_BITS-1:0] sar_val,
    input  logic [1:0]          addr,
    output logic [DATA_W-1:0]   rdata,
    output logic                start_flag,
    output logic [RES_BITS-1:0] res_word,
    output logic                irq
);
    localparam int LO_BITS = RES_BITS - DATA_W;

    logic [DATA_W-1:0]   ctrl_q;
    logic [RES_BITS-1:0] res_q;
    logic                irq_q;

    // Purpose: control register; a bus write wins over the self-clear.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wdata;
        end else if (commit) begin
            ctrl_q[START_BIT] <= 1'b0;
        end
    end

    // Purpose: result register and interrupt pulse.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            res_q <= '0;
            irq_q <= 1'b0;
        end else begin
            irq_q <= commit;
            if (commit) begin
                res_q <= sar_val;
            end
        end
    end

    // Purpose: read multiplexer.
    always_comb begin
        case (addr)
            ADDR_CTRL:   rdata = ctrl_q;
            ADDR_RES_HI: rdata = res_q[RES_BITS-1 -: DATA_W];
            ADDR_RES_LO: rdata = {res_q[LO_BITS-1:0], {(DATA_W-LO_BITS){1'b0}}};
            default:     rdata = '0;
        endcase
    end

    assign start_flag = ctrl_q[START_BIT];
    assign res_word   = res_q;
    assign irq        = irq_q;
endmodule

// File: rtl/adc_sar_top.sv
// Module: top of the single-shot conversion sequencer. Decodes the register
// bus and wires the phase sequencer, the approximation register and the
// register file together. Assumes the strobes are held for exactly one cycle.
module adc_sar_top
    import adc_sar_pkg::*;
#(
    parameter int RES_BITS      = 10,
    parameter int SAMPLE_CYCLES = 4,
    parameter int DATA_W        = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [1:0]          bus_addr,
    input  logic                bus_wr,
    input  logic                bus_rd,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    input  logic                cmp_in,
    output logic [RES_BITS-1:0] dac_code,
    output logic                eoc_irq
);
    localparam int CNT_MAX = (RES_BITS > SAMPLE_CYCLES) ? RES_BITS : SAMPLE_CYCLES;
    localparam int CNT_W   = $clog2(CNT_MAX);

    phase_t              phase;
    logic [CNT_W-1:0]    step_idx;
    logic                load_sar, step_en, commit;
    logic                ctrl_wr, start_w, rd_res;
    logic                start_flag;
    logic [RES_BITS-1:0] sar_val, res_word;

    // Purpose: bus decode.
    always_comb begin
        ctrl_wr = bus_wr && (bus_addr == ADDR_CTRL);
        start_w = bus_wdata[START_BIT];
        rd_res  = bus_rd && (bus_addr == ADDR_RES_HI || bus_addr == ADDR_RES_LO);
    end

    adc_sar_ctrl #(
        .RES_BITS(RES_BITS), .SAMPLE_CYCLES(SAMPLE_CYCLES), .CNT_W(CNT_W)
    ) u_ctrl (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .start_w(start_w),
        .rd_res(rd_res), .phase(phase), .step_idx(step_idx),
        .load_sar(load_sar), .step_en(step_en), .commit(commit)
    );

    adc_sar_approx #(
        .RES_BITS(RES_BITS), .CNT_W(CNT_W)
    ) u_sar (
        .clk(clk), .rst_n(rst_n), .load(load_sar), .step_en(step_en),
        .in_conv(phase == PH_CONV), .step_idx(step_idx), .cmp_in(cmp_in),
        .dac_code(dac_code), .sar_val(sar_val)
    );

    adc_sar_regs #(
        .RES_BITS(RES_BITS), .DATA_W(DATA_W)
    ) u_regs (
        .clk(clk), .rst_n(rst_n), .ctrl_wr(ctrl_wr), .wdata(bus_wdata),
        .commit(commit), .sar_val(sar_val), .addr(bus_addr),
        .rdata(bus_rdata), .start_flag(start_flag), .res_word(res_word),
        .irq(eoc_irq)
    );
endmodule

// File: rtl/adc_sar_checker.sv
// Module: property checker bound into the sequencer top.
module adc_sar_checker
    import adc_sar_pkg::*;
#(
    parameter int RES_BITS = 10,
    parameter int CNT_W    = 4
) (
    input logic                clk,
    input logic                rst_n,
    input logic                eoc_irq,
    input logic                start_flag,
    input logic [RES_BITS-1:0] res_word,
    input phase_t              phase,
    input logic                ctrl_wr,
    input logic                start_w,
    input logic                rd_res,
    input logic [RES_BITS-1:0] dac_code,
    input logic [CNT_W-1:0]    step_idx
);
    AST_BUSY_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        start_flag == (phase != PH_IDLE)); // R1
    AST_FLAG_CLEARED_AT_END: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |-> !start_flag); // R2
    AST_TRIAL_BIT_SET: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_CONV) |-> dac_code[step_idx]); // R4
    AST_IRQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        eoc_irq |=> !eoc_irq); // R7
    AST_RESULT_ONLY_WITH_IRQ: assert property (@(posedge clk) disable iff (!rst_n)
        !eoc_irq |-> $stable(res_word)); // R7
    AST_READ_DEFERS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && rd_res && !ctrl_wr) |=> (phase == PH_DONE && !eoc_irq)); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        (phase == PH_DONE && ctrl_wr) |=> (!eoc_irq && $stable(res_word))); // R9
    AST_ABORT_TO_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((phase == PH_SAMPLE || phase == PH_CONV) && ctrl_wr && !start_w)
        |=> (phase == PH_IDLE && !eoc_irq)); // R10
endmodule

bind adc_sar_top adc_sar_checker #(.RES_BITS(RES_BITS), .CNT_W(CNT_W)) u_chk (
    .clk(clk), .rst_n(rst_n), .eoc_irq(eoc_irq), .start_flag(start_flag),
    .res_word(res_word), .phase(phase), .ctrl_wr(ctrl_wr), .start_w(start_w),
    .rd_res(rd_res), .dac_code(dac_code), .step_idx(step_idx)
);

// File: tb/adc_sar_top_test.sv
// Bench: directed corners plus seeded random rounds over normal, read-collision,
// write-collision and abort scenarios, checked against a bench-side model.
module adc_sar_top_test;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic [1:0] bus_addr = 2'd0;
    logic       bus_wr = 1'b0;
    logic       bus_rd = 1'b0;
    logic [7:0] bus_wdata = 8'd0;
    logic [7:0] bus_rdata;
    logic       cmp_in;
    logic [9:0] dac_code;
    logic       eoc_irq;

    logic [9:0] tgt = 10'd0;
    logic [9:0] exp_res = 10'd0;
    logic [6:0] ctrl_lo = 7'd0;
    int         n_checks = 0;
    int         n_fail = 0;

    always #4 clk = ~clk;

    // Comparator model: keep the trial bit while the code does not exceed the level.
    assign cmp_in = (dac_code <= tgt);

    adc_sar_top uut (
        .clk(clk), .rst_n(rst_n), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_rd(bus_rd), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .cmp_in(cmp_in), .dac_code(dac_code), .eoc_irq(eoc_irq)
    );

    task automatic check(input string tag, input int act, input int exp);
        n_checks++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic wr(input logic [1:0] a, input logic [7:0] d);
        bus_addr  = a;
        bus_wdata = d;
        bus_wr    = 1'b1;
        tick();
        bus_wr    = 1'b0;
    endtask

    task automatic peek(input logic [1:0] a, output logic [7:0] v);
        bus_addr = a;
        #1;
        v = bus_rdata;
    endtask

    task automatic check_res(input string tag);
        logic [7:0] v;
        peek(2'd1, v);
        check({tag, " R5 high"}, int'(v), int'(exp_res[9:2]));
        peek(2'd2, v);
        check({tag, " R5 low"}, int'(v), int'({exp_res[1:0], 6'b0}));
    endtask

    // Normal conversion; dbl != 0 rewrites the start flag on that edge (R1).
    task automatic conv_normal(input logic [9:0] t, input int dbl);
        logic [7:0] v;
        tgt = t;
        wr(2'd0, {1'b1, ctrl_lo});
        for (int i = 1; i <= 14; i++) begin
            if (i == dbl) begin
                ctrl_lo = 7'($urandom);
                wr(2'd0, {1'b1, ctrl_lo});
            end else begin
                tick();
            end
            if (i == 4) check("R4 first trial", int'(dac_code), 'h200);
            if (i == 5) check("R4 second trial", int'(dac_code), int'((t & 10'h200) | 10'h100));
            if (i == 7) begin
                peek(2'd0, v);
                check("R1 busy flag", int'(v[7]), 1);
            end
        end
        check("R3 no early irq", int'(eoc_irq), 0);
        tick();
        check("R3 irq at edge 15", int'(eoc_irq), 1);
        exp_res = t;
        check_res("R4 result");
        peek(2'd0, v);
        check("R2 flag cleared", int'(v), int'({1'b0, ctrl_lo}));
        tick();
        check("R7 pulse width", int'(eoc_irq), 0);
    endtask

    task automatic conv_read_clash(input logic [9:0] t, input logic [1:0] ra);
        logic [7:0] v;
        tgt = t;
        wr(2'd0, {1'b1, ctrl_lo});
        for (int i = 1; i <= 14; i++) tick();
        bus_rd = 1'b1;
        peek(ra, v);
        check("R8 read sees old", int'(v),
              (ra == 2'd1) ? int'(exp_res[9:2]) : int'({exp_res[1:0], 6'b0}));
        tick();
        bus_rd = 1'b0;
        check("R8 irq deferred", int'(eoc_irq), 0);
        check_res("R8 old kept");
        tick();
        check("R8 irq after read", int'(eoc_irq), 1);
        exp_res = t;
        check_res("R8 new result");
        tick();
    endtask

    task automatic conv_write_clash(input logic [9:0] t, input logic [7:0] nw);
        logic [7:0] v;
        tgt = t;
        wr(2'd0, {1'b1, ctrl_lo});
        for (int i = 1; i <= 14; i++) tick();
        wr(2'd0, nw);
        ctrl_lo = nw[6:0];
        check("R9 irq suppressed", int'(eoc_irq), 0);
        check_res("R9 result kept");
        peek(2'd0, v);
        check("R9 ctrl value", int'(v), int'(nw));
        if (nw[7]) begin
            for (int i = 1; i <= 14; i++) tick();
            check("R9 restart no early irq", int'(eoc_irq), 0);
            tick();
            check("R9 restart irq", int'(eoc_irq), 1);
            exp_res = t;
            check_res("R9 restart result");
            tick();
        end else begin
            for (int i = 1; i <= 4; i++) begin
                tick();
                check("R9 no late irq", int'(eoc_irq), 0);
            end
        end
    endtask

    task automatic conv_abort(input logic [9:0] t, input int k);
        logic [7:0] v;
        int         seen;
        tgt = t;
        seen = 0;
        wr(2'd0, {1'b1, ctrl_lo});
        for (int i = 1; i < k; i++) tick();
        wr(2'd0, {1'b0, ctrl_lo});
        for (int i = 1; i <= 18; i++) begin
            tick();
            if (eoc_irq) seen++;
        end
        check("R10 no irq after abort", seen, 0);
        check_res("R10 result kept");
        peek(2'd0, v);
        check("R10 idle flag", int'(v), int'({1'b0, ctrl_lo}));
    endtask

    initial begin
        logic [7:0] v;
        int unsigned seed;
        seed = $urandom(32'd20240611);
        repeat (3) tick();
        check("R6 irq low in reset", int'(eoc_irq), 0);
        rst_n = 1'b1;
        tick();
        peek(2'd0, v); check("R6 ctrl reset", int'(v), 0);
        peek(2'd1, v); check("R6 high reset", int'(v), 0);
        peek(2'd2, v); check("R6 low reset", int'(v), 0);

        conv_normal(10'h3FF, 0);
        conv_normal(10'h000, 0);
        conv_normal(10'h2AA, 6);
        conv_read_clash(10'h155, 2'd1);
        conv_read_clash(10'h0C3, 2'd2);
        conv_write_clash(10'h3C0, 8'h05);
        conv_write_clash(10'h01F, 8'h81);
        conv_abort(10'h111, 1);
        conv_abort(10'h222, 14);

        for (int r = 0; r < 60; r++) begin
            logic [9:0] t;
            t = 10'($urandom);
            case ($urandom % 4)
                0: conv_normal(t, int'($urandom % 15));
                1: conv_read_clash(t, ($urandom % 2 == 0) ? 2'd1 : 2'd2);
                2: conv_write_clash(t, 8'($urandom));
                default: conv_abort(t, 1 + int'($urandom % 14));
            endcase
        end

        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        repeat (150000) @(posedge clk);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule